// File: doc/BRIEF.md
# ATA PIO Register-Access Timing Engine

This block sits behind a Wishbone slave port and turns each 32-bit bus access into one programmed-I/O read or write on a 16-bit parallel disk interface. The top bit of the word address picks the target. One value sends the access to the attached drives. The other value sends it to four local timing registers. For drive accesses the engine drives the chip select and register address lines, then runs a counted sequence of phases: address setup, strobe pulse, hold, and recovery. The strobe pulse is stretched while the drive holds its ready line low.

The bus sees an acknowledge only once the strobe and hold phases are over. The recovery interval then runs on its own, and any new request, local or remote, waits until it has expired. The four phase lengths are held in clock cycles in read/write registers. They reset to values that suit the slowest PIO mode at 100 MHz. A drive interrupt line is passed through one register stage, and a device reset output is held low while the engine is in reset.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset both strobes and both chip selects are high, the data output enable is low, and ACK and ERR are low. The local registers read back setup=6, pulse=28, hold=2, recovery=23.
- R2: An access with address bit 6 = 0 and word index bits 5:2 in 0..3 targets a local register. Index 0 is setup, 1 is pulse, 2 is hold and 3 is recovery. A write stores data bits 7:0 only when byte select bit 0 is 1. A read returns the value zero-extended. ACK is high in the cycle after the request, with no chip select or strobe activity.
- R3: A local access with word index 4..15 gets a one-cycle ERR instead of ACK and changes no register.
- R4: An access with address bit 6 = 1 goes to the drive. Address bit 5 = 1 pulls cs1_n low and bit 5 = 0 pulls cs0_n low; the two are never low together. Address bits 4:2 appear on the 3-bit drive address lines.
- R5: A chip select is low and the strobes are high for exactly `setup` cycles before the strobe falls.
- R6: With ready high the strobe (rd_n for reads, wr_n for writes) stays low for exactly `pulse` cycles. While ready, after a two-flop synchronizer, reads low, the strobe is held low and the count pauses.
- R7: After the strobe rises, the chip select stays low for exactly `hold` cycles. ACK follows in the next cycle, with the chip select released.
- R8: For a write, dd_out carries write data bits 15:0, and dd_oe is high from chip-select assertion until release. dd_oe is never high during a read.
- R9: A read returns the drive data sampled in the last strobe-low cycle, on read data bits 15:0, with bits 31:16 zero.
- R10: ACK lasts one cycle, and rd_n and wr_n are never low together.
- R11: After a drive access is acknowledged, no new access starts and no ACK is given for `recovery` cycles.
- R12: The synchronous active-high reset has the same effect as the asynchronous active-low reset, including aborting a strobe in progress and restoring the register defaults.
- R13: irq_out equals the interrupt input one cycle later. dsk_rst_n is low during reset and high afterwards.
- R14: A new value written to a timing register sets the length of that phase on the next drive access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous reset, active high |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Bus write enable |
| bus_adr | input | 5 | Word address bits 6:2 |
| bus_sel | input | 4 | Byte selects |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_ack | output | 1 | Acknowledge |
| bus_rty | output | 1 | Retry, always low |
| bus_err | output | 1 | Error |
| dsk_rst_n | output | 1 | Drive reset, active low |
| dsk_cs0_n | output | 1 | Chip select 0, active low |
| dsk_cs1_n | output | 1 | Chip select 1, active low |
| dsk_addr | output | 3 | Drive register address |
| dsk_rd_n | output | 1 | Read strobe, active low |
| dsk_wr_n | output | 1 | Write strobe, active low |
| dsk_dout | output | 16 | Data to drive |
| dsk_din | input | 16 | Data from drive |
| dsk_doe | output | 1 | Data output enable |
| dsk_rdy | input | 1 | Drive ready |
| dsk_irq | input | 1 | Drive interrupt request |
| irq_out | output | 1 | Registered interrupt |

## Verification
The assertions check on every cycle the properties that are safe at all times. These are: at most one strobe and at most one chip select low; a strobe only under a chip select; no output enable during a read strobe; a paused pulse while ready is low; a one-cycle ACK that never coincides with ERR; no start out of recovery; registers that stay stable unless written; and the interrupt delay. The exact phase lengths, the address decode, the returned read data and the recovery gap can only be shown by the bench scenarios. The same holds for the effect of reprogrammed registers, the stretch caused by ready, and the synchronous reset in mid-strobe, since these depend on counted intervals measured from the ports.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int unsigned TCNT_W = 8;
  typedef logic [TCNT_W-1:0] tcnt_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_RECOV
  } phase_t;

  // Counter load for a phase lasting 'cycles' clocks; zero behaves as one.
  function automatic tcnt_t phase_load(input tcnt_t cycles);
    return (cycles == '0) ? '0 : tcnt_t'(cycles - tcnt_t'(1));
  endfunction

  // True when a local word index lies inside the register window.
  function automatic logic local_index_ok(input logic [3:0] idx, input int unsigned n_regs);
    return 32'(idx) < n_regs;
  endfunction
endpackage

// File: rtl/pio_rdy_sync.sv
module pio_rdy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic srst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)   chain_q[s] <= 1'b1;
        else if (srst) chain_q[s] <= 1'b1;
        else if (s == 0) chain_q[s] <= async_in;
        else           chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
  import ata_pio_pkg::*;
#(
  parameter int unsigned SETUP_DEF = 6,
  parameter int unsigned PULSE_DEF = 28,
  parameter int unsigned HOLD_DEF  = 2,
  parameter int unsigned RECOV_DEF = 23
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       srst,
  input  logic       wr_en,
  input  logic [1:0] idx,
  input  tcnt_t      wr_val,
  output tcnt_t      rd_val,
  output tcnt_t      t_setup,
  output tcnt_t      t_pulse,
  output tcnt_t      t_hold,
  output tcnt_t      t_recov
);
  localparam int unsigned N_REGS = 4;
  localparam tcnt_t RST_VAL [N_REGS] = '{tcnt_t'(SETUP_DEF), tcnt_t'(PULSE_DEF),
                                         tcnt_t'(HOLD_DEF),  tcnt_t'(RECOV_DEF)};
  tcnt_t val [N_REGS];

  generate
    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
      tcnt_t q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                       q <= RST_VAL[g];
        else if (srst)                     q <= RST_VAL[g];
        else if (wr_en && idx == 2'(g))    q <= wr_val;
      end
      assign val[g] = q;
    end
  endgenerate

  assign rd_val  = val[idx];
  assign t_setup = val[0];
  assign t_pulse = val[1];
  assign t_hold  = val[2];
  assign t_recov = val[3];

  logic [N_REGS*TCNT_W-1:0] all_vals;
  assign all_vals = {val[3], val[2], val[1], val[0]};

  AST_REG_STABLE: assert property (@(posedge clk) disable iff (!arst_n || srst)
    !wr_en |=> $stable(all_vals)); // R2
endmodule

// File: rtl/pio_cycle_fsm.sv
module pio_cycle_fsm
  import ata_pio_pkg::*;
#(
  parameter int unsigned DD_W = 16,
  parameter int unsigned DA_W = 3
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            srst,
  input  logic            start,
  input  logic            start_we,
  input  logic            start_cs1,
  input  logic [DA_W-1:0] start_addr,
  input  logic [DD_W-1:0] start_wdata,
  input  tcnt_t           t_setup,
  input  tcnt_t           t_pulse,
  input  tcnt_t           t_hold,
  input  tcnt_t           t_recov,
  input  logic            ready_s,
  input  logic [DD_W-1:0] dd_in,
  output logic            idle,
  output logic            xfer_done,
  output logic [DD_W-1:0] rd_word,
  output logic            cs0_n,
  output logic            cs1_n,
  output logic [DA_W-1:0] da,
  output logic            rd_n,
  output logic            wr_n,
  output logic [DD_W-1:0] dd_out,
  output logic            dd_oe
);
  phase_t          phase_q;
  tcnt_t           cnt_q;
  logic            we_q, cs1_q;
  logic [DA_W-1:0] addr_q;
  logic [DD_W-1:0] wdata_q, rd_q;

  logic cnt_zero, pulse_end, in_xfer, strobe_on;
  assign cnt_zero  = (cnt_q == '0);
  assign pulse_end = (phase_q == PH_PULSE) && ready_s && cnt_zero;
  assign xfer_done = (phase_q == PH_HOLD) && cnt_zero;
  assign in_xfer   = (phase_q == PH_SETUP) || (phase_q == PH_PULSE) || (phase_q == PH_HOLD);
  assign strobe_on = (phase_q == PH_PULSE);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase_q <= PH_IDLE; cnt_q <= '0; we_q <= 1'b0; cs1_q <= 1'b0;
      addr_q <= '0; wdata_q <= '0; rd_q <= '0;
    end else if (srst) begin
      phase_q <= PH_IDLE; cnt_q <= '0; we_q <= 1'b0; cs1_q <= 1'b0;
      addr_q <= '0; wdata_q <= '0; rd_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          we_q    <= start_we;
          cs1_q   <= start_cs1;
          addr_q  <= start_addr;
          wdata_q <= start_wdata;
          cnt_q   <= phase_load(t_setup);
          phase_q <= PH_SETUP;
        end
        PH_SETUP: if (cnt_zero) begin
          cnt_q   <= phase_load(t_pulse);
          phase_q <= PH_PULSE;
        end else cnt_q <= cnt_q - tcnt_t'(1);
        PH_PULSE: if (ready_s) begin
          if (cnt_zero) begin
            if (!we_q) rd_q <= dd_in;
            cnt_q   <= phase_load(t_hold);
            phase_q <= PH_HOLD;
          end else cnt_q <= cnt_q - tcnt_t'(1);
        end
        PH_HOLD: if (cnt_zero) begin
          cnt_q   <= phase_load(t_recov);
          phase_q <= PH_RECOV;
        end else cnt_q <= cnt_q - tcnt_t'(1);
        PH_RECOV: if (cnt_zero) phase_q <= PH_IDLE;
                  else cnt_q <= cnt_q - tcnt_t'(1);
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign idle    = (phase_q == PH_IDLE);
  assign rd_word = rd_q;
  assign cs0_n   = !(in_xfer && !cs1_q);
  assign cs1_n   = !(in_xfer && cs1_q);
  assign da      = addr_q;
  assign rd_n    = !(strobe_on && !we_q);
  assign wr_n    = !(strobe_on && we_q);
  assign dd_out  = wdata_q;
  assign dd_oe   = in_xfer && we_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!arst_n || srst)
    !(!rd_n && !wr_n)); // R10
  AST_CS_EXCL: assert property (@(posedge clk) disable iff (!arst_n || srst)
    !(!cs0_n && !cs1_n)); // R4
  AST_STROBE_UNDER_CS: assert property (@(posedge clk) disable iff (!arst_n || srst)
    (!rd_n || !wr_n) |-> (!cs0_n || !cs1_n)); // R5
  AST_NO_OE_ON_READ: assert property (@(posedge clk) disable iff (!arst_n || srst)
    !rd_n |-> !dd_oe); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!arst_n || srst)
    (strobe_on && !ready_s) |=> strobe_on); // R6
  AST_RECOV_NO_START: assert property (@(posedge clk) disable iff (!arst_n || srst)
    (phase_q == PH_RECOV) |=> (phase_q == PH_RECOV || phase_q == PH_IDLE)); // R11
  AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!arst_n || srst)
    pulse_end |=> (phase_q == PH_HOLD)); // R7
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int unsigned BUS_W       = 32,
  parameter int unsigned SEL_W       = 4,
  parameter int unsigned ADR_W       = 5,
  parameter int unsigned DD_W        = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETUP_DEF   = 6,
  parameter int unsigned PULSE_DEF   = 28,
  parameter int unsigned HOLD_DEF    = 2,
  parameter int unsigned RECOV_DEF   = 23
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             srst,
  input  logic             bus_cyc,
  input  logic             bus_stb,
  input  logic             bus_we,
  input  logic [ADR_W-1:0] bus_adr,
  input  logic [SEL_W-1:0] bus_sel,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             bus_ack,
  output logic             bus_rty,
  output logic             bus_err,
  output logic             dsk_rst_n,
  output logic             dsk_cs0_n,
  output logic             dsk_cs1_n,
  output logic [2:0]       dsk_addr,
  output logic             dsk_rd_n,
  output logic             dsk_wr_n,
  output logic [DD_W-1:0]  dsk_dout,
  input  logic [DD_W-1:0]  dsk_din,
  output logic             dsk_doe,
  input  logic             dsk_rdy,
  input  logic             dsk_irq,
  output logic             irq_out
);
  localparam int unsigned SPACE_BIT = ADR_W - 1;
  localparam int unsigned CSSEL_BIT = ADR_W - 2;
  localparam int unsigned DA_W      = ADR_W - 2;
  localparam int unsigned N_REGS    = 4;

  logic ack_q, err_q, irq_q, drst_q;
  logic [BUS_W-1:0] rdata_q;

  logic  req, eng_idle, dev_start, loc_hit, loc_ok, reg_wr, xfer_done, ready_s;
  tcnt_t reg_rd, t_setup, t_pulse, t_hold, t_recov;
  logic [DD_W-1:0] rd_word;

  assign req       = bus_cyc && bus_stb && !ack_q && !err_q;
  assign dev_start = req && eng_idle && bus_adr[SPACE_BIT];
  assign loc_hit   = req && eng_idle && !bus_adr[SPACE_BIT];
  assign loc_ok    = local_index_ok(bus_adr[3:0], N_REGS);
  assign reg_wr    = loc_hit && loc_ok && bus_we && bus_sel[0];

  pio_timing_regs #(
    .SETUP_DEF(SETUP_DEF), .PULSE_DEF(PULSE_DEF),
    .HOLD_DEF(HOLD_DEF),   .RECOV_DEF(RECOV_DEF)
  ) u_regs (
    .clk(clk), .arst_n(arst_n), .srst(srst),
    .wr_en(reg_wr), .idx(bus_adr[1:0]), .wr_val(bus_wdata[TCNT_W-1:0]),
    .rd_val(reg_rd), .t_setup(t_setup), .t_pulse(t_pulse),
    .t_hold(t_hold), .t_recov(t_recov)
  );

  pio_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(arst_n), .srst(srst),
    .async_in(dsk_rdy), .sync_out(ready_s)
  );

  pio_cycle_fsm #(.DD_W(DD_W), .DA_W(DA_W)) u_fsm (
    .clk(clk), .arst_n(arst_n), .srst(srst),
    .start(dev_start), .start_we(bus_we), .start_cs1(bus_adr[CSSEL_BIT]),
    .start_addr(bus_adr[DA_W-1:0]), .start_wdata(bus_wdata[DD_W-1:0]),
    .t_setup(t_setup), .t_pulse(t_pulse), .t_hold(t_hold), .t_recov(t_recov),
    .ready_s(ready_s), .dd_in(dsk_din),
    .idle(eng_idle), .xfer_done(xfer_done), .rd_word(rd_word),
    .cs0_n(dsk_cs0_n), .cs1_n(dsk_cs1_n), .da(dsk_addr),
    .rd_n(dsk_rd_n), .wr_n(dsk_wr_n), .dd_out(dsk_dout), .dd_oe(dsk_doe)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ack_q <= 1'b0; err_q <= 1'b0; rdata_q <= '0; irq_q <= 1'b0; drst_q <= 1'b0;
    end else if (srst) begin
      ack_q <= 1'b0; err_q <= 1'b0; rdata_q <= '0; irq_q <= 1'b0; drst_q <= 1'b0;
    end else begin
      ack_q  <= (loc_hit && loc_ok) || xfer_done;
      err_q  <= loc_hit && !loc_ok;
      irq_q  <= dsk_irq;
      drst_q <= 1'b1;
      if (loc_hit && loc_ok)
        rdata_q <= {{(BUS_W-TCNT_W){1'b0}}, reg_rd};
      else if (xfer_done)
        rdata_q <= {{(BUS_W-DD_W){1'b0}}, rd_word};
    end
  end

  assign bus_ack   = ack_q;
  assign bus_err   = err_q;
  assign bus_rty   = 1'b0;
  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;
  assign dsk_rst_n = drst_q;

  logic unused_bits;
  assign unused_bits = ^{bus_sel[SEL_W-1:1], bus_wdata[BUS_W-1:DD_W]};

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!arst_n || srst)
    bus_ack |=> !bus_ack); // R10
  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!arst_n || srst)
    !(bus_ack && bus_err)); // R3
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!arst_n || srst)
    bus_err |=> !bus_err); // R3
  AST_IRQ_DELAY: assert property (@(posedge clk) disable iff (!arst_n || srst)
    1'b1 |=> (irq_out == $past(dsk_irq))); // R13
  AST_LOCAL_NO_DISK: assert property (@(posedge clk) disable iff (!arst_n || srst)
    (loc_hit && loc_ok) |=> (dsk_cs0_n && dsk_cs1_n)); // R2
endmodule

// File: tb/ata_pio_engine_tb.sv
`timescale 1ns/1ps
module ata_pio_engine_tb;
  localparam int T1 = 6, T2 = 28, T4 = 2, TEOC = 23;

  logic clk = 1'b0;
  logic arst_n = 1'b0, srst = 1'b0;
  logic cyc = 0, stb = 0, we = 0;
  logic [4:0] adr = '0;
  logic [3:0] sel = 4'hF;
  logic [31:0] wdat = '0, rdat;
  logic ack, rty, err, drst_n, cs0_n, cs1_n, rd_n, wr_n, doe, irq_o;
  logic [2:0] daddr;
  logic [15:0] dout, din = '0;
  logic rdy = 1'b1, irq_i = 1'b0;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  ata_pio_engine u_dut (
    .clk(clk), .arst_n(arst_n), .srst(srst),
    .bus_cyc(cyc), .bus_stb(stb), .bus_we(we), .bus_adr(adr), .bus_sel(sel),
    .bus_wdata(wdat), .bus_rdata(rdat), .bus_ack(ack), .bus_rty(rty), .bus_err(err),
    .dsk_rst_n(drst_n), .dsk_cs0_n(cs0_n), .dsk_cs1_n(cs1_n), .dsk_addr(daddr),
    .dsk_rd_n(rd_n), .dsk_wr_n(wr_n), .dsk_dout(dout), .dsk_din(din),
    .dsk_doe(doe), .dsk_rdy(rdy), .dsk_irq(irq_i), .irq_out(irq_o)
  );

  // {write, adr[6:2], write data, drive data}
  localparam logic [37:0] VEC [0:5] = '{
    {1'b1, 5'b10000, 16'h1234, 16'h0000},
    {1'b0, 5'b10111, 16'h0000, 16'hBEEF},
    {1'b1, 5'b11101, 16'hFFFF, 16'h0000},
    {1'b0, 5'b11110, 16'h0000, 16'h8001},
    {1'b0, 5'b10010, 16'h0000, 16'h0000},
    {1'b1, 5'b11011, 16'h00FF, 16'h5A5A}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic local_access(input logic w, input logic [3:0] idx, input logic [31:0] wd,
                              input logic [3:0] s, output logic [31:0] rd,
                              output logic a, output logic e, output logic quiet);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = {1'b0, idx}; wdat = wd; sel = s;
    @(negedge clk);
    a = ack; e = err; rd = rdat; quiet = cs0_n && cs1_n && rd_n && wr_n;
    cyc = 0; stb = 0; we = 0; sel = 4'hF;
  endtask

  task automatic dev_access(input logic w, input logic [4:0] a, input logic [15:0] wd,
                            input logic [15:0] dd, input int t1, input int t2,
                            input int t4, input int stall_w);
    int su, pw, hd;
    su = 0; pw = 0; hd = 0;
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; wdat = {16'hC3C3, wd}; din = dd;
    @(negedge clk);
    while (cs0_n && cs1_n) @(negedge clk);
    check(a[3] ? (!cs1_n && cs0_n) : (!cs0_n && cs1_n), "R4 chip select", {cs1_n, cs0_n}, a[3] ? 2'b01 : 2'b10);
    check(daddr == a[2:0], "R4 address lines", daddr, a[2:0]);
    check(doe == w, "R8 output enable", doe, w);
    if (w) check(dout == wd, "R8 write data", dout, wd);
    while (rd_n && wr_n) begin su++; @(negedge clk); end
    check(su == t1, "R5 setup length", su, t1);
    check(w ? (!wr_n && rd_n) : (!rd_n && wr_n), "R6 strobe select", {wr_n, rd_n}, w ? 2'b01 : 2'b10);
    while (!(rd_n && wr_n)) begin
      pw++;
      if (stall_w != 0 && pw == stall_w) rdy = 1'b1;
      @(negedge clk);
    end
    if (stall_w == 0) check(pw == t2, "R6 pulse length", pw, t2);
    else check(pw >= stall_w + t2 && pw <= stall_w + t2 + 2, "R6 stretched pulse", pw, stall_w + t2 + 1);
    while (!ack) begin hd++; @(negedge clk); end
    check(hd == t4, "R7 hold length", hd, t4);
    check(cs0_n && cs1_n && !doe, "R7 release at ack", {cs1_n, cs0_n, doe}, 3'b110);
    if (!w) check(rdat == {16'h0, dd}, "R9 read data", rdat, {16'h0, dd});
    cyc = 0; stb = 0; we = 0;
    @(negedge clk);
    check(!ack, "R10 ack one cycle", ack, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic a, e, q;
    int g;
    repeat (3) @(negedge clk);
    check(drst_n == 1'b0, "R13 drive reset during reset", drst_n, 0);
    arst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check(rd_n && wr_n && cs0_n && cs1_n && !doe && !ack && !err, "R1 idle outputs",
          {rd_n, wr_n, cs0_n, cs1_n, doe, ack, err}, 7'b1111000);
    check(drst_n == 1'b1, "R13 drive reset released", drst_n, 1);

    local_access(0, 4'd0, 0, 4'hF, rd, a, e, q); check(a && rd == 6,  "R1 setup default", rd, 6);
    check(q, "R2 no disk activity", q, 1);
    local_access(0, 4'd1, 0, 4'hF, rd, a, e, q); check(a && rd == 28, "R1 pulse default", rd, 28);
    local_access(0, 4'd2, 0, 4'hF, rd, a, e, q); check(a && rd == 2,  "R1 hold default", rd, 2);
    local_access(0, 4'd3, 0, 4'hF, rd, a, e, q); check(a && rd == 23, "R1 recovery default", rd, 23);

    local_access(1, 4'd3, 32'h55, 4'hE, rd, a, e, q);
    check(a, "R2 write ack", a, 1);
    local_access(0, 4'd3, 0, 4'hF, rd, a, e, q); check(rd == 23, "R2 sel0 low ignored", rd, 23);

    local_access(1, 4'd5, 32'h11, 4'hF, rd, a, e, q);
    check(e && !a, "R3 err on index 5", {e, a}, 2'b10);
    local_access(0, 4'd15, 0, 4'hF, rd, a, e, q);
    check(e && !a, "R3 err on index 15", {e, a}, 2'b10);
    local_access(0, 4'd1, 0, 4'hF, rd, a, e, q); check(rd == 28, "R3 no register change", rd, 28);

    for (int i = 0; i < 6; i++) begin
      dev_access(VEC[i][37], VEC[i][36:32], VEC[i][31:16], VEC[i][15:0], T1, T2, T4, 0);
      repeat (TEOC + 2) @(negedge clk);
    end

    // R6 ready stall
    rdy = 1'b0;
    dev_access(0, 5'b10001, 0, 16'h7E7E, T1, T2, T4, 40);

    // R11 recovery gap before a local read
    repeat (TEOC + 2) @(negedge clk);
    dev_access(1, 5'b10100, 16'h0F0F, 0, T1, T2, T4, 0);
    cyc = 1; stb = 1; we = 0; adr = 5'b00000;
    g = 0;
    while (!ack) begin @(negedge clk); g++; end
    check(g == TEOC, "R11 recovery gap", g, TEOC);
    check(rdat == 6, "R11 held read data", rdat, 6);
    cyc = 0; stb = 0;

    // R14 reprogrammed timing
    local_access(1, 4'd0, 32'd3, 4'hF, rd, a, e, q);
    local_access(1, 4'd1, 32'd4, 4'hF, rd, a, e, q);
    local_access(1, 4'd2, 32'd5, 4'hF, rd, a, e, q);
    local_access(1, 4'd3, 32'd7, 4'hF, rd, a, e, q);
    dev_access(0, 5'b11010, 0, 16'hA11A, 3, 4, 5, 0);
    repeat (10) @(negedge clk);
    local_access(0, 4'd2, 0, 4'hF, rd, a, e, q); check(rd == 5, "R14 hold readback", rd, 5);

    // R12 synchronous reset mid-strobe
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = 5'b10011; wdat = 32'h0000ABCD;
    while (wr_n) @(negedge clk);
    cyc = 0; stb = 0; srst = 1'b1;
    @(negedge clk);
    check(rd_n && wr_n && cs0_n && cs1_n && !doe, "R12 strobe aborted",
          {rd_n, wr_n, cs0_n, cs1_n, doe}, 5'b11110);
    check(drst_n == 1'b0, "R12 drive reset asserted", drst_n, 0);
    srst = 1'b0;
    @(negedge clk);
    local_access(0, 4'd0, 0, 4'hF, rd, a, e, q); check(rd == 6, "R12 setup default restored", rd, 6);
    local_access(0, 4'd3, 0, 4'hF, rd, a, e, q); check(rd == 23, "R12 recovery default restored", rd, 23);

    // R13 interrupt pass-through
    @(negedge clk); irq_i = 1'b1;
    @(negedge clk); check(irq_o == 1'b1, "R13 irq rise", irq_o, 1);
    irq_i = 1'b0;
    @(negedge clk); check(irq_o == 1'b0, "R13 irq fall", irq_o, 0);
    check(rty == 1'b0, "R10 retry low", rty, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule